// File: doc/BRIEF.md
# Banked Work-RAM Window with Capture Latches

This block serves a CPU address space with two small memory regions. The first is an 8 KB window at 0x6000–0x7FFF. The second is an auxiliary RAM at 0x5000–0x5FFF that software can always read and write. A control byte selects what the window shows. Four pairs of code values each map one 8 KB page of a 32 KB battery-backed RAM into the window. Every other code value sends window traffic to a separate default backing bank. One of the paging codes also copies window writes into that default bank.

A second function works like a small lock. Three specific control codes arm it. While it is armed, a write anywhere in the auxiliary region sets an armed flag, and writes at three exact addresses also store their data into three byte latches. While the flag is set, reads at three matching exact window addresses return those latches in place of RAM. Reading the last of them clears the flag.

Storage depths are parameters so that the block can be elaborated cheaply. A window page and the default bank hold 2^WIN_AW bytes, and the auxiliary RAM holds 2^AUX_AW bytes. Addresses inside a region alias modulo that depth. All reads are registered.

Top module: `wram_window`

## Requirements
- R1: Asynchronous active-low reset clears the control byte to 0x00, the armed flag and all three capture latches to 0x00. It also clears the read data output to 0x00.
- R2: A write whose address ANDed with 0xE001 equals 0xA001 loads the control byte with the write data. Writes at other addresses, including 0xA000, leave it unchanged.
- R3: When the control byte is 0xE4 or 0xEC, window accesses use battery page 0. Codes 0xE5/0xED use page 1, 0xE6/0xEE use page 2, and 0xE7/0xEF use page 3. The byte offset is cpu_addr[WIN_AW-1:0].
- R4: When the control byte is 0xE4 or 0xEC, a window write stores into battery page 0 and also into the default bank at the same offset.
- R5: With any other control code, window reads and writes use the default bank.
- R6: Addresses 0x5000–0x5FFF read and write the auxiliary RAM at offset cpu_addr[AUX_AW-1:0], whatever the control byte holds.
- R7: When the control byte is 0xA1, 0xA5 or 0xA9, any write in 0x5000–0x5FFF sets the armed flag. Writes at exactly 0x5000, 0x5010 and 0x5013 also load latches 0, 1 and 2. The auxiliary RAM is written in all cases.
- R8: While the flag is armed, reads at exactly 0x6000, 0x6010 and 0x6013 return latches 0, 1 and 2 in place of RAM. A read at 0x6013 clears the flag. The flag clears in no other way except reset.
- R9: cpu_rdata updates on the clock edge that samples cpu_rd and otherwise holds its value. A read outside 0x5000–0x7FFF returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | Write data |
| cpu_wr | input | 1 | Write strobe, one cycle per access |
| cpu_rd | input | 1 | Read strobe, one cycle per access |
| cpu_rdata | output | 8 | Registered read data |

## Verification
The bench targets several corner cases where a wrong design would behave visibly differently:
- The dual write under 0xE4/0xEC. A design that drops it leaves stale data in the default bank when paging is turned off.
- The near-miss codes 0xE0 and 0xAD, and the ignored write at 0xA000. A design that decodes a loose bit field or a wider mask would switch pages or arm when it should not.
- Address 0x6012 between the latch addresses. A design that compares too few address bits would return a latch there.
- Arming by a write that captures nothing, after reset. A design that fails to clear the latches would return stale bytes.
- Reading the latches again after 0x6013. A design that never disarms would keep returning latch data.

// File: rtl/wram_window.sv
module wram_window #(
  parameter int WIN_AW = 8,
  parameter int AUX_AW = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] cpu_addr,
  input  logic [7:0]  cpu_wdata,
  input  logic        cpu_wr,
  input  logic        cpu_rd,
  output logic [7:0]  cpu_rdata
);
  localparam int WIN_DEPTH = 1 << WIN_AW;
  localparam int BAT_DEPTH = 4 * WIN_DEPTH;
  localparam int AUX_DEPTH = 1 << AUX_AW;

  logic [7:0] ctrl_q;
  logic       armed_q;
  logic [7:0] lat0_q, lat1_q, lat2_q;

  logic [7:0] bat_mem  [BAT_DEPTH];
  logic [7:0] dflt_mem [WIN_DEPTH];
  logic [7:0] aux_mem  [AUX_DEPTH];

  wire in_aux    = cpu_addr[15:12] == 4'h5;
  wire in_win    = cpu_addr[15:13] == 3'b011;
  wire ctrl_hit  = (cpu_addr & 16'hE001) == 16'hA001;
  wire page_code = (ctrl_q[7:4] == 4'hE) && ctrl_q[2];
  wire arm_code  = (ctrl_q == 8'hA1) || (ctrl_q == 8'hA5) || (ctrl_q == 8'hA9);
  wire [1:0] page = ctrl_q[1:0];

  wire [WIN_AW-1:0] win_off = cpu_addr[WIN_AW-1:0];
  wire [AUX_AW-1:0] aux_off = cpu_addr[AUX_AW-1:0];
  wire [WIN_AW+1:0] bat_idx = {page, win_off};

  wire hit0 = armed_q && (cpu_addr == 16'h6000);
  wire hit1 = armed_q && (cpu_addr == 16'h6010);
  wire hit2 = armed_q && (cpu_addr == 16'h6013);

  wire bat_we  = cpu_wr && in_win && page_code;
  wire dflt_we = cpu_wr && in_win && (!page_code || (page == 2'd0));
  wire aux_we  = cpu_wr && in_aux;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        ctrl_q <= 8'h00;
    else if (cpu_wr && ctrl_hit) ctrl_q <= cpu_wdata;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      armed_q <= 1'b0;
      lat0_q  <= 8'h00;
      lat1_q  <= 8'h00;
      lat2_q  <= 8'h00;
    end else if (aux_we && arm_code) begin
      armed_q <= 1'b1;
      if (cpu_addr == 16'h5000) lat0_q <= cpu_wdata;
      if (cpu_addr == 16'h5010) lat1_q <= cpu_wdata;
      if (cpu_addr == 16'h5013) lat2_q <= cpu_wdata;
    end else if (cpu_rd && hit2) begin
      armed_q <= 1'b0;
    end

  always_ff @(posedge clk) begin
    if (bat_we)  bat_mem[bat_idx]  <= cpu_wdata;
    if (dflt_we) dflt_mem[win_off] <= cpu_wdata;
    if (aux_we)  aux_mem[aux_off]  <= cpu_wdata;
  end

  logic [7:0] rd_mux;
  always_comb begin
    rd_mux = 8'h00;
    if (hit0)           rd_mux = lat0_q;
    else if (hit1)      rd_mux = lat1_q;
    else if (hit2)      rd_mux = lat2_q;
    else if (in_win)    rd_mux = page_code ? bat_mem[bat_idx] : dflt_mem[win_off];
    else if (in_aux)    rd_mux = aux_mem[aux_off];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      cpu_rdata <= 8'h00;
    else if (cpu_rd) cpu_rdata <= rd_mux;
endmodule

// File: rtl/wram_window_chk.sv
module wram_window_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] cpu_addr,
  input logic [7:0]  cpu_wdata,
  input logic        cpu_wr,
  input logic        cpu_rd,
  input logic [7:0]  cpu_rdata,
  input logic [7:0]  ctrl_q,
  input logic        armed_q
);
  p_reset_r1: assert property (@(posedge clk)
    !rst_n |=> (ctrl_q == 8'h00 && !armed_q && cpu_rdata == 8'h00));

  p_ctrl_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && ((cpu_addr & 16'hE001) == 16'hA001)) |=> ctrl_q == $past(cpu_wdata));

  p_arm_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr[15:12] == 4'h5 &&
     (ctrl_q == 8'hA1 || ctrl_q == 8'hA5 || ctrl_q == 8'hA9)) |=> armed_q);

  p_disarm_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rd && !cpu_wr && armed_q && cpu_addr == 16'h6013) |=> !armed_q);

  p_only_disarm_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(armed_q) |-> $past(cpu_rd && cpu_addr == 16'h6013));

  p_unmapped_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rd && cpu_addr[15:12] != 4'h5 && cpu_addr[15:13] != 3'b011) |=> cpu_rdata == 8'h00);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_rd |=> $stable(cpu_rdata));
endmodule

bind wram_window wram_window_chk i_chk (
  .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
  .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .cpu_rdata(cpu_rdata),
  .ctrl_q(ctrl_q), .armed_q(armed_q)
);

// File: tb/test_wram_window.sv
`timescale 1ns/1ps
module test_wram_window;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = 16'h0000;
  logic [7:0]  cpu_wdata = 8'h00;
  logic        cpu_wr = 1'b0;
  logic        cpu_rd = 1'b0;
  logic [7:0]  cpu_rdata;

  int n_tests = 0;
  int n_fail  = 0;

  logic [7:0] m_bat  [4][256];
  logic [7:0] m_dflt [256];
  logic [7:0] m_aux  [256];
  logic [7:0] m_ctrl;
  logic       m_armed;
  logic [7:0] m_lat [3];

  wram_window i_wram_window (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .cpu_rdata(cpu_rdata)
  );

  always #2.5 clk = ~clk;

  function automatic int page_of(logic [7:0] c);
    case (c)
      8'hE4, 8'hEC: return 0;
      8'hE5, 8'hED: return 1;
      8'hE6, 8'hEE: return 2;
      8'hE7, 8'hEF: return 3;
      default:      return -1;
    endcase
  endfunction

  function automatic logic [7:0] m_read(logic [15:0] a);
    int p;
    p = page_of(m_ctrl);
    if (m_armed && a == 16'h6000) return m_lat[0];
    if (m_armed && a == 16'h6010) return m_lat[1];
    if (m_armed && a == 16'h6013) return m_lat[2];
    if (a >= 16'h6000 && a <= 16'h7FFF) return (p < 0) ? m_dflt[a[7:0]] : m_bat[p][a[7:0]];
    if (a >= 16'h5000 && a <= 16'h5FFF) return m_aux[a[7:0]];
    return 8'h00;
  endfunction

  function automatic string tag_of(logic [15:0] a);
    if (m_armed && (a == 16'h6000 || a == 16'h6010 || a == 16'h6013)) return "R8";
    if (a >= 16'h6000 && a <= 16'h7FFF) return (page_of(m_ctrl) < 0) ? "R5" : "R3";
    if (a >= 16'h5000 && a <= 16'h5FFF) return "R6";
    return "R9";
  endfunction

  task automatic check(string tag, logic [7:0] got, logic [7:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [15:0] a, logic [7:0] d);
    int p;
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
    @(negedge clk);
    cpu_wr = 1'b0;
    p = page_of(m_ctrl);
    if ((a & 16'hE001) == 16'hA001) m_ctrl = d;
    else if (a >= 16'h5000 && a <= 16'h5FFF) begin
      m_aux[a[7:0]] = d;
      if (m_ctrl == 8'hA1 || m_ctrl == 8'hA5 || m_ctrl == 8'hA9) begin
        m_armed = 1'b1;
        if (a == 16'h5000) m_lat[0] = d;
        if (a == 16'h5010) m_lat[1] = d;
        if (a == 16'h5013) m_lat[2] = d;
      end
    end else if (a >= 16'h6000 && a <= 16'h7FFF) begin
      if (p >= 0) m_bat[p][a[7:0]] = d;
      if (p <= 0) m_dflt[a[7:0]] = d;
    end
  endtask

  task automatic rd_chk(logic [15:0] a, string tag);
    logic [7:0] exp;
    @(negedge clk);
    cpu_addr = a; cpu_rd = 1'b1;
    exp = m_read(a);
    @(negedge clk);
    cpu_rd = 1'b0;
    check(tag, cpu_rdata, exp);
    if (m_armed && a == 16'h6013) m_armed = 1'b0;
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] held;
    logic [7:0] codes [15] = '{8'hE4, 8'hE5, 8'hE6, 8'hE7, 8'hEC, 8'hED, 8'hEE, 8'hEF,
                               8'hA1, 8'hA5, 8'hA9, 8'h00, 8'hE0, 8'hAD, 8'h7F};
    void'($urandom(32'd1234));
    m_ctrl = 8'h00; m_armed = 1'b0;
    for (int i = 0; i < 3; i++) m_lat[i] = 8'h00;
    repeat (3) @(negedge clk);
    check("R1", cpu_rdata, 8'h00);
    rst_n = 1'b1;

    for (int p = 0; p < 4; p++) begin
      wr(16'hA001, 8'hE4 + 8'(p));
      for (int i = 0; i < 256; i++) wr(16'h6000 + 16'(i), 8'($urandom));
    end
    wr(16'hA001, 8'h00);
    for (int i = 0; i < 256; i++) wr(16'h7F00 + 16'(i), 8'($urandom));
    for (int i = 0; i < 256; i++) wr(16'h5000 + 16'(i), 8'($urandom));

    // R1: arm without capture, latches still hold their reset value
    wr(16'hA001, 8'hA1);
    wr(16'h5001, 8'h99);
    rd_chk(16'h6000, "R1");
    rd_chk(16'h6010, "R1");
    rd_chk(16'h6013, "R1");
    rd_chk(16'h6000, "R8");

    // R2: decode mask, ignored write at 0xA000, alias at 0xBF7F
    wr(16'hA001, 8'hE5);
    wr(16'hA000, 8'h00);
    rd_chk(16'h6033, "R2");
    wr(16'hBF7F, 8'hEE);
    rd_chk(16'h6033, "R2");

    // R4: dual write under 0xE4 and 0xEC
    wr(16'hA001, 8'hE4);
    wr(16'h6042, 8'h5A);
    wr(16'hA001, 8'hEC);
    wr(16'h7143, 8'hC3);
    wr(16'hA001, 8'h00);
    rd_chk(16'h6042, "R4");
    rd_chk(16'h6043, "R4");
    wr(16'hA001, 8'hE6);
    wr(16'h6044, 8'h77);
    wr(16'hA001, 8'h00);
    rd_chk(16'h6044, "R4");

    // R5: near-miss codes go to the default bank
    wr(16'hA001, 8'hE0);
    rd_chk(16'h6044, "R5");
    wr(16'hA001, 8'hAD);
    wr(16'h5000, 8'hEE);
    rd_chk(16'h6000, "R5");

    // R7/R8: capture and read-back
    wr(16'hA001, 8'hA5);
    wr(16'h5000, 8'h11);
    wr(16'h5010, 8'h22);
    wr(16'h5013, 8'h33);
    wr(16'hA001, 8'hE6);
    rd_chk(16'h6000, "R7");
    rd_chk(16'h6010, "R7");
    rd_chk(16'h6012, "R8");
    rd_chk(16'h5013, "R6");
    rd_chk(16'h6013, "R8");
    rd_chk(16'h6000, "R8");
    rd_chk(16'h6010, "R8");

    // R9: unmapped reads and hold
    rd_chk(16'h8000, "R9");
    rd_chk(16'h4FFF, "R9");
    rd_chk(16'h6001, "R9");
    held = cpu_rdata;
    repeat (3) @(negedge clk);
    check("R9", cpu_rdata, held);

    for (int n = 0; n < 4000; n++) begin
      int op;
      logic [15:0] a;
      op = int'($urandom % 8);
      case (op)
        0: wr(16'hA001 | (16'($urandom) & 16'h1FFE), codes[$urandom % 15]);
        1: wr(16'h6000 | (16'($urandom) & 16'h1FFF), 8'($urandom));
        2: begin
             case ($urandom % 4)
               0: a = 16'h5000;
               1: a = 16'h5010;
               2: a = 16'h5013;
               default: a = 16'h5000 | (16'($urandom) & 16'h0FFF);
             endcase
             wr(a, 8'($urandom));
           end
        3: begin
             case ($urandom % 3)
               0: a = 16'h6000;
               1: a = 16'h6010;
               default: a = 16'h6013;
             endcase
             rd_chk(a, tag_of(a));
           end
        4, 5: begin
             a = 16'h6000 | (16'($urandom) & 16'h1FFF);
             rd_chk(a, tag_of(a));
           end
        6: begin
             a = 16'h5000 | (16'($urandom) & 16'h0FFF);
             rd_chk(a, tag_of(a));
           end
        default: begin
             a = 16'($urandom);
             rd_chk(a, tag_of(a));
           end
      endcase
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule